// File: doc/BRIEF.md
# Cache Tag Store with Hit Comparator

The block holds the tag half of a direct-mapped cache directory. A set index picks one entry; each entry keeps a tag field and three status flags (valid, dirty, write-through). The stored tag of the selected entry is compared in the same cycle against a tag presented on the input bus, and a hit flag is raised when they agree. A burst-ready indication for the data cache is derived from that hit, the status flags, the direction of the current processor cycle and an external qualifier.

Lookups and readback are purely combinational from index to outputs. Updates are captured on the rising clock edge, with separate enables for the tag field and the status field. A synchronous clear wipes every status flag in one cycle, invalidating the whole directory. A mode input turns the status flags into plain user storage with no effect on hit or burst-ready. Two chip selects of opposite polarity allow several stores to be stacked in depth, and a sleep input silences the block while it keeps its contents.

Top module: `cache_tag_store`

## Requirements
- R1: While rst_ni is low, every status flag of every entry is cleared; stat_o reads 0 at any index, and hit_o and rdy_o are 0.
- R2: With the block selected and the relevant enable high, tag_o and stat_o show the entry at idx_i in the same cycle; a write made at a rising edge is visible after that edge.
- R3: With user_mode_i low, hit_o is 1 exactly when the stored tag at idx_i equals tag_i and that entry's valid flag (stat bit 0) is 1.
- R4: tag_we_i writes only the tag field and stat_we_i writes only the status field; the other field of the entry keeps its value.
- R5: When clr_ni is low at a rising edge, every status flag of every entry reads 0 after that edge.
- R6: When clr_ni is low at the same edge as a status write, the clear wins; a tag write in that cycle still lands.
- R7: With user_mode_i high, hit_o depends only on tag equality, and the status bits are stored and read back unchanged with no effect on hit.
- R8: tag_o, stat_o and rdy_o each read 0 when their own enable (tag_oe_i, stat_oe_i, rdy_oe_i) is low; hit_o does not depend on any of them.
- R9: The block is selected only with cs_ni low and cs_i high; when deselected, hit_o, rdy_o, tag_o and stat_o are 0 and writes are ignored.
- R10: While sleep_i is high, the block behaves as deselected, and stored contents are kept for when it wakes.
- R11: For a read cycle (wr_cycle_i low), rdy_o equals hit_o AND rdy_qual_i, given rdy_oe_i high.
- R12: For a write cycle with user_mode_i low, rdy_o is 1 only on a hit whose write-through flag (stat bit 2) is 0 and rdy_qual_i is 1; with user_mode_i high, the write-through flag has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, writes and clear on rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low, clears status flags |
| idx_i | input | IDX_W | Set index selecting one entry |
| tag_i | input | TAG_W | Compare tag and tag write data |
| tag_we_i | input | 1 | Tag field write enable |
| tag_oe_i | input | 1 | Tag readback output enable |
| tag_o | output | TAG_W | Stored tag of the selected entry |
| stat_i | input | 3 | Status write data: bit 0 valid, bit 1 dirty, bit 2 write-through |
| stat_we_i | input | 1 | Status field write enable |
| stat_oe_i | input | 1 | Status readback output enable |
| stat_o | output | 3 | Stored status of the selected entry |
| cs_ni | input | 1 | Chip select, active low |
| cs_i | input | 1 | Chip select, active high |
| sleep_i | input | 1 | Low-power request, active high |
| user_mode_i | input | 1 | 1: status bits are plain storage |
| clr_ni | input | 1 | Synchronous clear of all status flags, active low |
| wr_cycle_i | input | 1 | Current processor cycle is a write |
| rdy_qual_i | input | 1 | External burst-ready qualifier |
| rdy_oe_i | input | 1 | Burst-ready output enable |
| hit_o | output | 1 | Tag match indication |
| rdy_o | output | 1 | Burst-ready indication |

## Verification
The properties on stored contents assume the index is held steady across the edge that follows a write; where the index moves they make no claim, and the stimulus keeps the index fixed for the cycle after every write. The clear properties assume no reset edge falls between clear and the following sample, which the stimulus respects by raising reset once at the start. Sweeps cover every index and every compare tag of a small configuration, in both status modes, so equality is checked against all mismatching values as well as the match.

// File: rtl/cts_pkg.sv
package cts_pkg;
  // bit 0 valid, bit 1 dirty, bit 2 write-through
  typedef struct packed {
    logic wt;
    logic dirty;
    logic valid;
  } stat_t;

  localparam int STAT_W = 3;
endpackage

// File: rtl/cts_tag_array.sv
module cts_tag_array #(
  parameter int IDX_W = 8,
  parameter int TAG_W = 12
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TAG_W-1:0] wdata_i,
  output logic [TAG_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[idx_i] <= wdata_i;
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/cts_stat_array.sv
module cts_stat_array
  import cts_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  stat_t            wdata_i,
  output stat_t            rdata_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] sel;
  stat_t            stat_q [DEPTH];

  assign sel = DEPTH'(1) << idx_i;

  // per-entry flops so one clear can hit every entry in a single edge
  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                stat_q[e] <= '0;
      else if (!clr_ni)           stat_q[e] <= '0;
      else if (we_i && sel[e])    stat_q[e] <= wdata_i;
    end
  end

  assign rdata_o = stat_q[idx_i];
endmodule

// File: rtl/cts_match.sv
module cts_match
  import cts_pkg::*;
#(
  parameter int TAG_W = 12
) (
  input  logic             act_i,
  input  logic             user_mode_i,
  input  logic [TAG_W-1:0] stored_tag_i,
  input  stat_t            stored_stat_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             wr_cycle_i,
  input  logic             rdy_qual_i,
  input  logic             rdy_oe_i,
  output logic             hit_o,
  output logic             rdy_o
);
  logic [TAG_W-1:0] bit_eq;
  logic             tag_eq;
  logic             valid_ok;
  logic             wt_ok;

  for (genvar b = 0; b < TAG_W; b++) begin : g_cmp
    assign bit_eq[b] = ~(stored_tag_i[b] ^ tag_i[b]);
  end

  assign tag_eq   = &bit_eq;
  assign valid_ok = user_mode_i | stored_stat_i.valid;
  // write-through lines need the write to reach memory, so no early ready
  assign wt_ok    = user_mode_i | ~wr_cycle_i | ~stored_stat_i.wt;

  assign hit_o = act_i & tag_eq & valid_ok;
  assign rdy_o = hit_o & rdy_qual_i & wt_ok & rdy_oe_i;
endmodule

// File: rtl/cache_tag_store.sv
module cache_tag_store
  import cts_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int TAG_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic              tag_we_i,
  input  logic              tag_oe_i,
  output logic [TAG_W-1:0]  tag_o,
  input  logic [STAT_W-1:0] stat_i,
  input  logic              stat_we_i,
  input  logic              stat_oe_i,
  output logic [STAT_W-1:0] stat_o,
  input  logic              cs_ni,
  input  logic              cs_i,
  input  logic              sleep_i,
  input  logic              user_mode_i,
  input  logic              clr_ni,
  input  logic              wr_cycle_i,
  input  logic              rdy_qual_i,
  input  logic              rdy_oe_i,
  output logic              hit_o,
  output logic              rdy_o
);
  logic             act;
  logic [TAG_W-1:0] rd_tag;
  stat_t            rd_stat;
  stat_t            wr_stat;

  assign act     = ~cs_ni & cs_i & ~sleep_i;
  assign wr_stat = stat_t'(stat_i);

  cts_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tag (
    .clk_i   (clk_i),
    .we_i    (act & tag_we_i),
    .idx_i   (idx_i),
    .wdata_i (tag_i),
    .rdata_o (rd_tag)
  );

  cts_stat_array #(.IDX_W(IDX_W)) u_stat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_ni  (clr_ni),
    .we_i    (act & stat_we_i),
    .idx_i   (idx_i),
    .wdata_i (wr_stat),
    .rdata_o (rd_stat)
  );

  cts_match #(.TAG_W(TAG_W)) u_match (
    .act_i         (act),
    .user_mode_i   (user_mode_i),
    .stored_tag_i  (rd_tag),
    .stored_stat_i (rd_stat),
    .tag_i         (tag_i),
    .wr_cycle_i    (wr_cycle_i),
    .rdy_qual_i    (rdy_qual_i),
    .rdy_oe_i      (rdy_oe_i),
    .hit_o         (hit_o),
    .rdy_o         (rdy_o)
  );

  assign tag_o  = (act & tag_oe_i)  ? rd_tag          : '0;
  assign stat_o = (act & stat_oe_i) ? STAT_W'(rd_stat) : '0;
endmodule

// File: rtl/cts_checker.sv
module cts_checker
  import cts_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int TAG_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [IDX_W-1:0]  idx_i,
  input logic [TAG_W-1:0]  tag_i,
  input logic              tag_we_i,
  input logic              tag_oe_i,
  input logic [TAG_W-1:0]  tag_o,
  input logic [STAT_W-1:0] stat_i,
  input logic              stat_we_i,
  input logic [STAT_W-1:0] stat_o,
  input logic              cs_ni,
  input logic              cs_i,
  input logic              sleep_i,
  input logic              user_mode_i,
  input logic              clr_ni,
  input logic              wr_cycle_i,
  input logic              rdy_qual_i,
  input logic              rdy_oe_i,
  input logic              hit_o,
  input logic              rdy_o,
  input logic              act,
  input logic [TAG_W-1:0]  rd_tag,
  input stat_t             rd_stat
);
  assert_hit_needs_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!user_mode_i && hit_o) |-> (rd_stat.valid && rd_tag == tag_i));

  assert_stat_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && stat_we_i && clr_ni) |=> (!$stable(idx_i) || STAT_W'(rd_stat) == $past(stat_i)));

  assert_tag_untouched_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_we_i && !tag_we_i) |=> (!$stable(idx_i) || rd_tag == $past(rd_tag)));

  assert_clear_all_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> rd_stat == '0);

  assert_tag_oe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tag_oe_i |-> tag_o == '0);

  assert_deselect_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || !cs_i) |-> (!hit_o && !rdy_o && tag_o == '0 && stat_o == '0));

  assert_sleep_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> (!hit_o && !rdy_o && stat_o == '0));

  assert_sleep_keeps_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && clr_ni) |=> (!$stable(idx_i) || (rd_tag == $past(rd_tag) && rd_stat == $past(rd_stat))));

  assert_read_ready_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && rdy_oe_i && rdy_qual_i && hit_o && !wr_cycle_i) |-> rdy_o);

  assert_ready_needs_hit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> (hit_o && rdy_qual_i));

  assert_wt_blocks_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!user_mode_i && wr_cycle_i && rd_stat.wt) |-> !rdy_o);
endmodule

bind cache_tag_store cts_checker #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .idx_i       (idx_i),
  .tag_i       (tag_i),
  .tag_we_i    (tag_we_i),
  .tag_oe_i    (tag_oe_i),
  .tag_o       (tag_o),
  .stat_i      (stat_i),
  .stat_we_i   (stat_we_i),
  .stat_o      (stat_o),
  .cs_ni       (cs_ni),
  .cs_i        (cs_i),
  .sleep_i     (sleep_i),
  .user_mode_i (user_mode_i),
  .clr_ni      (clr_ni),
  .wr_cycle_i  (wr_cycle_i),
  .rdy_qual_i  (rdy_qual_i),
  .rdy_oe_i    (rdy_oe_i),
  .hit_o       (hit_o),
  .rdy_o       (rdy_o),
  .act         (act),
  .rd_tag      (rd_tag),
  .rd_stat     (rd_stat)
);

// File: tb/sim_cache_tag_store.sv
module sim_cache_tag_store;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 4;
  localparam int TAG_W = 5;
  localparam int DEPTH = 1 << IDX_W;
  localparam int TVALS = 1 << TAG_W;

  logic             clk = 0;
  logic             rst_ni;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic             tag_we, tag_oe;
  logic [TAG_W-1:0] tag_o;
  logic [2:0]       stat;
  logic             stat_we, stat_oe;
  logic [2:0]       stat_o;
  logic             cs_ni, cs_i, sleep, user_mode, clr_ni;
  logic             wr_cycle, rdy_qual, rdy_oe;
  logic             hit_o, rdy_o;

  logic [TAG_W-1:0] mt [DEPTH];
  logic [2:0]       ms [DEPTH];

  int total = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .idx_i(idx), .tag_i(tag),
    .tag_we_i(tag_we), .tag_oe_i(tag_oe), .tag_o(tag_o),
    .stat_i(stat), .stat_we_i(stat_we), .stat_oe_i(stat_oe), .stat_o(stat_o),
    .cs_ni(cs_ni), .cs_i(cs_i), .sleep_i(sleep), .user_mode_i(user_mode),
    .clr_ni(clr_ni), .wr_cycle_i(wr_cycle), .rdy_qual_i(rdy_qual),
    .rdy_oe_i(rdy_oe), .hit_o(hit_o), .rdy_o(rdy_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic defaults();
    tag_we = 0; stat_we = 0; tag_oe = 1; stat_oe = 1; rdy_oe = 1;
    cs_ni = 0; cs_i = 1; sleep = 0; user_mode = 0; clr_ni = 1;
    wr_cycle = 0; rdy_qual = 1; idx = '0; tag = '0; stat = '0;
  endtask

  // drive at negedge, edge in between captures, release at next negedge
  task automatic do_write(input int i, input logic [TAG_W-1:0] t, input logic [2:0] s,
                          input bit twe, input bit swe);
    @(negedge clk);
    idx = IDX_W'(i); tag = t; stat = s; tag_we = twe; stat_we = swe;
    @(negedge clk);
    tag_we = 0; stat_we = 0;
  endtask

  task automatic look(input int i, input logic [TAG_W-1:0] t);
    idx = IDX_W'(i); tag = t;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    defaults();
    rst_ni = 0;
    repeat (3) @(negedge clk);
    // R1: status cleared under reset
    for (int i = 0; i < DEPTH; i++) begin
      look(i, '0);
      chk("R1 stat_o", stat_o, 0);
      chk("R1 hit_o", hit_o, 0);
      chk("R1 rdy_o", rdy_o, 0);
    end
    @(negedge clk);
    rst_ni = 1;

    for (int i = 0; i < DEPTH; i++) begin
      mt[i] = TAG_W'((i * 7 + 3) % TVALS);
      ms[i] = 3'(i % 8);
      do_write(i, mt[i], ms[i], 1, 1);
    end

    // R2: combinational readback
    for (int i = 0; i < DEPTH; i++) begin
      look(i, '0);
      chk("R2 tag_o", tag_o, mt[i]);
      chk("R2 stat_o", stat_o, ms[i]);
    end

    // R3 / R11: dedicated mode read sweep
    for (int i = 0; i < DEPTH; i++) begin
      for (int t = 0; t < TVALS; t++) begin
        logic eh;
        look(i, TAG_W'(t));
        eh = (TAG_W'(t) == mt[i]) && ms[i][0];
        chk("R3 hit", hit_o, eh);
        chk("R11 read rdy", rdy_o, eh);
      end
      rdy_qual = 0;
      look(i, mt[i]);
      chk("R11 qual low", rdy_o, 0);
      rdy_qual = 1;
    end

    // R7: user mode, equality only
    user_mode = 1;
    for (int i = 0; i < DEPTH; i++) begin
      for (int t = 0; t < TVALS; t++) begin
        look(i, TAG_W'(t));
        chk("R7 hit", hit_o, TAG_W'(t) == mt[i]);
      end
    end
    user_mode = 0;

    // R12: write cycles in both modes
    wr_cycle = 1;
    for (int i = 0; i < DEPTH; i++) begin
      for (int m = 0; m < 2; m++) begin
        for (int q = 0; q < 2; q++) begin
          logic eh, er;
          user_mode = m[0]; rdy_qual = q[0];
          look(i, mt[i]);
          eh = m[0] | ms[i][0];
          er = eh & q[0] & (m[0] | ~ms[i][2]);
          chk("R12 write rdy", rdy_o, er);
        end
      end
    end
    defaults();

    // R4: independent field writes
    do_write(3, 5'h1e, 3'b000, 1, 0);
    mt[3] = 5'h1e;
    look(3, '0);
    chk("R4 tag only tag", tag_o, 5'h1e);
    chk("R4 tag only stat", stat_o, ms[3]);
    do_write(4, 5'h00, 3'b101, 0, 1);
    ms[4] = 3'b101;
    look(4, '0);
    chk("R4 stat only tag", tag_o, mt[4]);
    chk("R4 stat only stat", stat_o, 3'b101);

    // R7: status kept verbatim in user mode
    user_mode = 1;
    do_write(6, mt[6], 3'b110, 0, 1);
    ms[6] = 3'b110;
    look(6, mt[6]);
    chk("R7 stat stored", stat_o, 3'b110);
    chk("R7 hit no valid", hit_o, 1);
    user_mode = 0;
    look(6, mt[6]);
    chk("R7 dedicated hit", hit_o, 0);

    // R8: output enables
    look(1, mt[1]);
    tag_oe = 0; #1;
    chk("R8 tag_o off", tag_o, 0);
    chk("R8 hit kept", hit_o, 1);
    stat_oe = 0; #1;
    chk("R8 stat_o off", stat_o, 0);
    rdy_oe = 0; #1;
    chk("R8 rdy_o off", rdy_o, 0);
    chk("R8 hit kept2", hit_o, 1);
    defaults();

    // R9: both selects needed; writes blocked when deselected
    cs_ni = 1;
    look(1, mt[1]);
    chk("R9 cs_ni hit", hit_o, 0);
    chk("R9 cs_ni tag_o", tag_o, 0);
    do_write(1, 5'h00, 3'b000, 1, 1);
    cs_ni = 0; cs_i = 0;
    look(1, mt[1]);
    chk("R9 cs_i hit", hit_o, 0);
    do_write(1, 5'h00, 3'b000, 1, 1);
    cs_i = 1;
    look(1, mt[1]);
    chk("R9 tag kept", tag_o, mt[1]);
    chk("R9 stat kept", stat_o, ms[1]);
    chk("R9 hit back", hit_o, 1);

    // R10: sleep silences and keeps contents
    sleep = 1;
    look(5, mt[5]);
    chk("R10 hit", hit_o, 0);
    chk("R10 rdy", rdy_o, 0);
    chk("R10 stat_o", stat_o, 0);
    do_write(5, 5'h00, 3'b000, 1, 1);
    sleep = 0;
    look(5, mt[5]);
    chk("R10 tag kept", tag_o, mt[5]);
    chk("R10 stat kept", stat_o, ms[5]);

    // R5 / R6: clear with simultaneous writes
    @(negedge clk);
    idx = 5; tag = 5'h1f; stat = 3'b111; tag_we = 1; stat_we = 1; clr_ni = 0;
    @(negedge clk);
    tag_we = 0; stat_we = 0; clr_ni = 1;
    mt[5] = 5'h1f;
    look(5, '0);
    chk("R6 tag landed", tag_o, 5'h1f);
    chk("R6 clear wins", stat_o, 0);
    for (int i = 0; i < DEPTH; i++) begin
      look(i, mt[i]);
      chk("R5 stat cleared", stat_o, 0);
      chk("R5 hit gone", hit_o, 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule